// File: doc/BRIEF.md
# Serial-Load Output Expander with Holding Register

This block is a parameterized serial-to-parallel output expander. A host shifts data in one bit at a time: each rising edge of a shift strobe pushes the serial bit into the first stage and moves every other stage one place toward the last. A separate latch strobe copies the whole shift stage into a holding register, and that register drives the parallel outputs. Loading new data therefore never disturbs the outputs until the host commits it. The last shift stage is also driven out as a cascade bit, so several expanders can be chained behind one serial port, in the way an SPI master drives a chain of output registers.

Both strobes and the serial data bit arrive as plain inputs. They pass through the same synchronizer depth inside one system clock domain, and the strobes are rising-edge detected. A dedicated active-low clear input empties the shift stage at once, without waiting for a clock, and leaves the holding register alone. An active-low output enable blanks the parallel outputs. High impedance is represented as a cleared valid flag with the data forced to zero. The held value survives blanking. The system reset brings every register to zero.

Top module: `sr_latch_expander`

## Requirements
- R1: On each rising edge of `shift_strobe`, the shift stage becomes `{old[W-2:0], ser_in}`. Bit 0 is the first stage and bit W-1 is the last. After W strobes carrying the bits of V, most significant bit first, the shift stage equals V.
- R2: `cascade_out` always equals the last shift stage (bit W-1) and does not depend on `oe_n`.
- R3: On each rising edge of `latch_strobe`, the holding register takes the shift stage value. With `oe_n` low, `par_out` shows the holding register and `par_valid` is 1.
- R4: A shift strobe leaves the holding register unchanged, and a latch strobe leaves the shift stage unchanged.
- R5: While `clr_n` is low, the shift stage is zero. It clears without waiting for a clock edge, shift strobes have no effect, and the holding register keeps its value.
- R6: While `oe_n` is high, `par_out` is zero and `par_valid` is 0. The holding register is kept and reappears when `oe_n` returns low.
- R7: When both strobes rise in the same cycle, the holding register captures the shift stage value from before that shift.
- R8: After `rst_n` is released, the shift stage and the holding register are zero. `cascade_out` is 0, and `par_out` is zero.
- R9: A strobe held high causes exactly one action. A further action needs a new low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, clears all registers |
| ser_in | input | 1 | Serial data bit |
| shift_strobe | input | 1 | Shift clock, acts on its rising edge |
| latch_strobe | input | 1 | Holding register clock, acts on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear of the shift stage only |
| oe_n | input | 1 | Active-low parallel output enable |
| par_out | output | W | Parallel outputs from the holding register, zero when blanked |
| par_valid | output | 1 | 1 when the parallel outputs are driven, 0 for high impedance |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
The shift and the latch capture can fall in the same cycle. The bench provokes this by raising both strobes on the same clock edge, with a known pattern in the shift stage and a serial bit that changes it. It then judges the result two ways. The parallel outputs must show the pattern from before the shift, and a second, separate latch strobe must then expose the shifted pattern. The clear input can also meet a shift strobe. In that case, the shift stage must stay zero while the holding register keeps its value.

// File: rtl/sr_latch_expander_pkg.sv
package sr_latch_expander_pkg;

  // One shift step: new bit enters stage 0, stage W-1 is dropped.
  function automatic logic [63:0] shift_step(input logic [63:0] q, input logic d,
                                             input int unsigned w);
    logic [63:0] r;
    r = (q << 1) | {63'd0, d};
    for (int i = 0; i < 64; i++) begin
      if (i >= w) r[i] = 1'b0;
    end
    return r;
  endfunction

  // Rising edge from current and previous sample.
  function automatic logic rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/sr_sync_bank.sv
module sr_sync_bank #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sr_edge_det.sv
module sr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  import sr_latch_expander_pkg::*;
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign pulse = rise(level, prev);
endmodule

// File: rtl/sr_shift_stage.sv
module sr_shift_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         d,
  output logic [W-1:0] q
);
  import sr_latch_expander_pkg::*;
  logic [63:0] nxt_wide;
  logic [W-1:0] nxt;

  always_comb begin
    nxt_wide = shift_step({{(64-W){1'b0}}, q}, d, W);
    nxt      = nxt_wide[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (fire) q <= nxt;
  end
endmodule

// File: rtl/sr_hold_stage.sv
module sr_hold_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (fire) q <= d;
  end
endmodule

// File: rtl/sr_latch_expander.sv
module sr_latch_expander #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         shift_strobe,
  input  logic         latch_strobe,
  input  logic         clr_n,
  input  logic         oe_n,
  output logic [W-1:0] par_out,
  output logic         par_valid,
  output logic         cascade_out
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, synced;
  logic             ser_bit, shift_lvl, latch_lvl;
  logic             shift_fire, latch_fire;
  logic             shift_rst_n;
  logic [W-1:0]     shift_q, hold_q;

  assign raw_in = {latch_strobe, shift_strobe, ser_in};

  sr_sync_bank #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );

  assign ser_bit   = synced[0];
  assign shift_lvl = synced[1];
  assign latch_lvl = synced[2];

  sr_edge_det u_shift_edge (
    .clk(clk), .rst_n(rst_n), .level(shift_lvl), .pulse(shift_fire)
  );
  sr_edge_det u_latch_edge (
    .clk(clk), .rst_n(rst_n), .level(latch_lvl), .pulse(latch_fire)
  );

  assign shift_rst_n = rst_n & clr_n;

  sr_shift_stage #(.W(W)) u_shift (
    .clk(clk), .rst_n(shift_rst_n), .fire(shift_fire), .d(ser_bit), .q(shift_q)
  );

  sr_hold_stage #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .fire(latch_fire), .d(shift_q), .q(hold_q)
  );

  assign par_valid   = ~oe_n;
  assign par_out     = oe_n ? '0 : hold_q;
  assign cascade_out = shift_q[W-1];
endmodule

// File: rtl/sr_latch_expander_chk.sv
module sr_latch_expander_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_n,
  input logic         oe_n,
  input logic         ser_bit,
  input logic         shift_fire,
  input logic         latch_fire,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] par_out,
  input logic         par_valid,
  input logic         cascade_out
);
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    shift_fire |=> shift_q == {$past(shift_q[W-2:0]), $past(ser_bit)});     // R1
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !shift_fire |=> $stable(shift_q));                                       // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fire |=> $stable(hold_q));                                        // R4
  AST_LATCH_PRE: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    latch_fire |=> hold_q == $past(shift_q));                                // R7
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> shift_q == '0);                                               // R5
  AST_OE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (par_out == '0) && !par_valid);                                 // R6
  AST_CASCADE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_out == shift_q[W-1]);                                            // R2
  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> !shift_fire);                                             // R9
endmodule

bind sr_latch_expander sr_latch_expander_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .oe_n(oe_n), .ser_bit(ser_bit),
  .shift_fire(shift_fire), .latch_fire(latch_fire), .shift_q(shift_q),
  .hold_q(hold_q), .par_out(par_out), .par_valid(par_valid),
  .cascade_out(cascade_out)
);

// File: tb/sim_sr_latch_expander.sv
module sim_sr_latch_expander;
  localparam int W       = 8;
  localparam int CLK_PER = 10;
  localparam int WD_MAX  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ser_in = 1'b0, shift_strobe = 1'b0, latch_strobe = 1'b0;
  logic clr_n = 1'b1, oe_n = 1'b0;
  logic [W-1:0] par_out;
  logic par_valid, cascade_out;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [W-1:0] m_shift, m_hold;

  always #(CLK_PER/2) clk = ~clk;

  sr_latch_expander #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_strobe(shift_strobe),
    .latch_strobe(latch_strobe), .clr_n(clr_n), .oe_n(oe_n),
    .par_out(par_out), .par_valid(par_valid), .cascade_out(cascade_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic do_shift, input logic do_latch, input logic bit_in);
    ser_in = bit_in;
    shift_strobe = do_shift;
    latch_strobe = do_latch;
    tick(5);
    shift_strobe = 1'b0;
    latch_strobe = 1'b0;
    tick(5);
    if (do_latch) m_hold = m_shift;
    if (do_shift && clr_n) m_shift = {m_shift[W-2:0], bit_in};
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_MAX && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_shift = '0;
    m_hold  = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R8 reset state
    chk("R8 par_out", par_out, '0);
    chk("R8 cascade", {7'd0, cascade_out}, 8'd0);
    chk("R8 par_valid", {7'd0, par_valid}, 8'd1);

    // Sweep all byte values: R1 shifting, R2 cascade, R4 isolation, R3 latch
    for (int v = 0; v < 256; v++) begin
      for (int b = W - 1; b >= 0; b--) begin
        strobe(1'b1, 1'b0, v[b]);
        chk("R2 cascade", {7'd0, cascade_out}, {7'd0, m_shift[W-1]});
      end
      chk("R4 hold kept during shift", par_out, m_hold);
      strobe(1'b0, 1'b1, 1'b0);
      chk("R1/R3 latched value", par_out, v[W-1:0]);
      chk("R4 shift kept by latch", {7'd0, cascade_out}, {7'd0, v[W-1]});
    end

    // R9: strobe held high shifts once
    m_shift = 8'hFF;
    for (int b = 0; b < W; b++) strobe(1'b1, 1'b0, 1'b1);
    ser_in = 1'b0;
    shift_strobe = 1'b1;
    tick(30);
    shift_strobe = 1'b0;
    tick(5);
    m_shift = {m_shift[W-2:0], 1'b0};
    strobe(1'b0, 1'b1, 1'b0);
    chk("R9 one shift per edge", par_out, 8'hFE);

    // R7: both strobes in the same cycle
    for (int b = W - 1; b >= 0; b--) strobe(1'b1, 1'b0, 8'hA5 >> b);
    strobe(1'b1, 1'b1, 1'b1);
    chk("R7 latch takes pre-shift", par_out, 8'hA5);
    strobe(1'b0, 1'b1, 1'b0);
    chk("R7 shifted value after", par_out, 8'h4B);

    // R6: output enable
    oe_n = 1'b1;
    tick(1);
    chk("R6 blanked data", par_out, '0);
    chk("R6 valid low", {7'd0, par_valid}, 8'd0);
    chk("R2 cascade ignores oe_n", {7'd0, cascade_out}, {7'd0, m_shift[W-1]});
    oe_n = 1'b0;
    tick(1);
    chk("R6 hold kept", par_out, 8'h4B);

    // R5: asynchronous clear
    for (int b = W - 1; b >= 0; b--) strobe(1'b1, 1'b0, 8'h81 >> b);
    chk("R5 setup cascade", {7'd0, cascade_out}, 8'd1);
    #2 clr_n = 1'b0;
    #1;
    chk("R5 async clear", {7'd0, cascade_out}, 8'd0);
    chk("R5 hold kept", par_out, 8'h4B);
    m_shift = '0;
    strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    chk("R5 shift ignored in clear", par_out, 8'h00);
    clr_n = 1'b1;
    tick(2);
    strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    chk("R5 resumes after clear", par_out, 8'h01);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule